// File: doc/BRIEF.md
# Status and Array Write Protection Guard

This block decides, cycle by cycle, whether a serial memory device may program its status register or a location of its data array. It keeps three pieces of state: a write-enable latch, a two-bit zone field that marks the upper quarter, the upper half or the whole array as read-only, and a pin-enable bit that makes an external active-low guard pin count. The zone field and the pin-enable bit stand for nonvolatile cells. The command engine in front of the block supplies the strobes: latch set and clear, status-value load, commit at the end of the frame and end of programming. It also supplies a busy flag while a programming cycle runs.

The block returns two permission outputs and the status byte image. The array permission depends on the latch, on the zone and on busy, and never on the guard pin. The status permission is refused while the hardware lock is active, which means the guard pin is low and pin-enable is set. A status value is only staged by a load. It takes effect on the following commit, and a falling edge of the guard pin while the frame is still selected throws it away. Once committed, the pin no longer affects it.

Top module: `wrprot_guard`

## Requirements
- R1: After reset the write-enable latch, the zone field and pin-enable are all 0, so the idle status byte reads 0x00.
- R2: While busy is 0 the status byte is {pin-enable at bit 7, zeros at bits 6..4, zone at bits 3..2, write-enable at bit 1, 0 at bit 0}. While busy is 1 it reads 0xFF.
- R3: The set strobe sets the write-enable latch at the next edge. The clear strobe clears it whatever the guard pin does, and wins over set when both arrive together. End of programming also clears it.
- R4: The zone selects the protected addresses by the top two address bits (default 14-bit address): 00 protects none, 01 protects 0x3000..0x3FFF, 10 protects 0x2000..0x3FFF, 11 protects all.
- R5: arr_ok is 1 exactly when the latch is set, the address lies outside the protected zone and busy is 0, at any level of the guard pin.
- R6: sr_ok is 1 exactly when the latch is set, busy is 0, and the guard pin is high or pin-enable is 0.
- R7: A load while sr_ok is 1 and no commit is present stages sr_data bit 7 (pin-enable) and bits 3..2 (zone). The next commit applies them. Other bits, refused loads, a load with commit in the same cycle, and a deselect before commit leave the status unchanged.
- R8: A falling guard pin while selected, with pin-enable 1 and a value staged, discards the staged value. A fall after the commit leaves the committed value in place.
- R9: While busy is 1 the set strobe, clear strobe and load are ignored and both permissions are 0.
- R10: Pin-enable cannot go from 1 to 0 while the guard pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| guard_pin_n | input | 1 | External write guard pin, low requests protection |
| sel_n | input | 1 | Frame select, low while a command frame is in progress |
| busy | input | 1 | Programming cycle in progress |
| cycle_done | input | 1 | Strobe at the end of a programming cycle |
| set_wen | input | 1 | Set write-enable latch strobe |
| clr_wen | input | 1 | Clear write-enable latch strobe |
| arr_addr | input | ADDR_W | Proposed array address |
| sr_load | input | 1 | Status value received strobe |
| sr_data | input | 8 | Requested status value |
| sr_commit | input | 1 | Frame end strobe that starts the status programming |
| arr_ok | output | 1 | Array write permitted |
| sr_ok | output | 1 | Status write permitted |
| status_byte | output | 8 | Status byte image |

## Verification
On every cycle, the embedded properties confirm that an array grant implies the latch is set, and that the hardware lock and busy both deny a status grant. They also check that a full zone refuses every array grant, that the clear strobe takes effect, that a pin fall during a staged write discards it, and that pin-enable holds while the pin stays low. Only the bench's scenarios can show the zone boundaries at exact addresses, the staging of loaded values through to the committed byte, and the effect of ignored strobes during busy. The same holds for a pin fall that arrives after the commit. The bench compares all three outputs every cycle against its own model under directed and random strobes.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;

    // Status byte bit positions (decoded by the command engine)
    localparam int unsigned ST_PIN_EN = 7;
    localparam int unsigned ST_ZONE_H = 3;
    localparam int unsigned ST_ZONE_L = 2;
    localparam int unsigned ST_WR_EN  = 1;
    localparam int unsigned ST_BUSY   = 0;
    localparam int unsigned ST_W      = 8;

    typedef enum logic [1:0] {
        ZONE_NONE    = 2'b00,
        ZONE_QUARTER = 2'b01,
        ZONE_HALF    = 2'b10,
        ZONE_ALL     = 2'b11
    } zone_e;

    typedef struct packed {
        logic       wr_en;
        logic       pin_en;
        logic [1:0] zone;
        logic       pend;
        logic       pend_pin_en;
        logic [1:0] pend_zone;
    } guard_state_t;

endpackage

// File: rtl/wrprot_zone.sv
module wrprot_zone
    import wrprot_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  logic [1:0]        zone,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int unsigned TOP = ADDR_W - 1;

    logic [1:0] quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign quarter = addr[TOP -: 2];
        end else begin : g_narrow
            assign quarter = {addr[0], addr[0]};
        end
    endgenerate

    always_comb begin
        case (zone_e'(zone))
            ZONE_NONE:    hit = 1'b0;
            ZONE_QUARTER: hit = (quarter == 2'b11);
            ZONE_HALF:    hit = quarter[1];
            default:      hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/wrprot_edge.sv
module wrprot_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fell
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = pin_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign fell = prev_q & ~pin_n;

endmodule

// File: rtl/wrprot_guard.sv
module wrprot_guard
    import wrprot_pkg::*;
#(
    parameter int unsigned ADDR_W      = 14,
    parameter logic [1:0]  INIT_ZONE   = 2'b00,
    parameter logic        INIT_PIN_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard_pin_n,
    input  logic              sel_n,
    input  logic              busy,
    input  logic              cycle_done,
    input  logic              set_wen,
    input  logic              clr_wen,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              sr_load,
    input  logic [7:0]        sr_data,
    input  logic              sr_commit,
    output logic              arr_ok,
    output logic              sr_ok,
    output logic [7:0]        status_byte
);
    localparam guard_state_t RESET_ST = '{
        wr_en: 1'b0, pin_en: INIT_PIN_EN, zone: INIT_ZONE,
        pend: 1'b0, pend_pin_en: 1'b0, pend_zone: 2'b00
    };

    guard_state_t st_d, st_q;
    logic zone_hit;
    logic pin_fell;
    logic hw_lock;

    wrprot_zone #(.ADDR_W(ADDR_W)) u_zone (
        .zone (st_q.zone),
        .addr (arr_addr),
        .hit  (zone_hit)
    );

    wrprot_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (guard_pin_n),
        .fell  (pin_fell)
    );

    always_comb begin
        st_d    = st_q;
        hw_lock = st_q.pin_en & ~guard_pin_n;
        sr_ok   = st_q.wr_en & ~hw_lock & ~busy;
        arr_ok  = st_q.wr_en & ~zone_hit & ~busy;

        // write-enable latch: clear beats set, both blocked during programming
        if (!busy && set_wen)  st_d.wr_en = 1'b1;
        if (!busy && clr_wen)  st_d.wr_en = 1'b0;
        if (cycle_done)        st_d.wr_en = 1'b0;

        // guard pin falling inside the frame discards a staged value
        if (st_q.pend && !sel_n && pin_fell && st_q.pin_en) st_d.pend = 1'b0;

        // commit applies the staged value and empties the stage
        if (sr_commit && st_q.pend) begin
            st_d.pin_en = st_q.pend_pin_en;
            st_d.zone   = st_q.pend_zone;
        end
        if (sr_commit) st_d.pend = 1'b0;

        // stage a new value only when permitted and not on a commit cycle
        if (sr_load && sr_ok && !sr_commit) begin
            st_d.pend        = 1'b1;
            st_d.pend_pin_en = sr_data[ST_PIN_EN];
            st_d.pend_zone   = sr_data[ST_ZONE_H:ST_ZONE_L];
        end

        if (sel_n) st_d.pend = 1'b0;

        if (busy) begin
            status_byte = '1;
        end else begin
            status_byte            = '0;
            status_byte[ST_PIN_EN] = st_q.pin_en;
            status_byte[ST_ZONE_H:ST_ZONE_L] = st_q.zone;
            status_byte[ST_WR_EN]  = st_q.wr_en;
            status_byte[ST_BUSY]   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    AST_ARR_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        arr_ok |-> status_byte[ST_WR_EN]); // R5

    AST_LOCK_DENIES_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_pin_n && st_q.pin_en) |-> !sr_ok); // R6

    AST_FULL_ZONE_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.zone == 2'b11) |-> !arr_ok); // R4

    AST_CLEAR_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wen && !busy) |=> !st_q.wr_en); // R3

    AST_BUSY_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!arr_ok && !sr_ok)); // R9

    AST_FALL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !sel_n && pin_fell && st_q.pin_en) |=> !st_q.pend); // R8

    AST_PIN_EN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pin_en && !guard_pin_n && !pin_fell) |=> st_q.pin_en); // R10

endmodule

// File: tb/wrprot_guard_bench.sv
module wrprot_guard_bench;

    localparam int AW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic guard_pin_n = 1'b1, sel_n = 1'b1, busy = 1'b0, cycle_done = 1'b0;
    logic set_wen = 1'b0, clr_wen = 1'b0, sr_load = 1'b0, sr_commit = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [7:0] sr_data = '0;
    logic arr_ok, sr_ok;
    logic [7:0] status_byte;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // reference model state
    logic m_wen, m_pin_en, m_pend, m_ppin, m_prev;
    logic [1:0] m_zone, m_pzone;

    always #5 clk = ~clk;

    wrprot_guard u_wrprot_guard (
        .clk(clk), .rst_n(rst_n), .guard_pin_n(guard_pin_n), .sel_n(sel_n),
        .busy(busy), .cycle_done(cycle_done), .set_wen(set_wen), .clr_wen(clr_wen),
        .arr_addr(arr_addr), .sr_load(sr_load), .sr_data(sr_data), .sr_commit(sr_commit),
        .arr_ok(arr_ok), .sr_ok(sr_ok), .status_byte(status_byte)
    );

    function automatic logic in_zone(input logic [1:0] z, input logic [AW-1:0] a);
        case (z)
            2'b00: return 1'b0;
            2'b01: return a[AW-1:AW-2] == 2'b11;
            2'b10: return a[AW-1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        if (busy) return 8'hFF;
        return {m_pin_en, 3'b000, m_zone, m_wen, 1'b0};
    endfunction

    function automatic logic exp_sr_ok();
        return m_wen && !(m_pin_en && !guard_pin_n) && !busy;
    endfunction

    function automatic logic exp_arr_ok();
        return m_wen && !in_zone(m_zone, arr_addr) && !busy;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_wen = 0; m_pin_en = 0; m_zone = 0; m_pend = 0; m_ppin = 0; m_pzone = 0; m_prev = 1;
    endtask

    task automatic model_advance();
        logic n_wen, n_pend, ok;
        n_wen = m_wen; n_pend = m_pend;
        ok = exp_sr_ok();
        if (!busy && set_wen) n_wen = 1;
        if (!busy && clr_wen) n_wen = 0;
        if (cycle_done) n_wen = 0;
        if (m_pend && !sel_n && m_prev && !guard_pin_n && m_pin_en) n_pend = 0;
        if (sr_commit && m_pend) begin
            m_pin_en = m_ppin; m_zone = m_pzone;
        end
        if (sr_commit) n_pend = 0;
        if (sr_load && ok && !sr_commit) begin
            n_pend = 1; m_ppin = sr_data[7]; m_pzone = sr_data[3:2];
        end
        if (sel_n) n_pend = 0;
        m_wen = n_wen; m_pend = n_pend; m_prev = guard_pin_n;
    endtask

    // drive one cycle of inputs, compare outputs, advance the model
    task automatic step(input logic pin, input logic sel, input logic bz, input logic dn,
                        input logic sw, input logic cw, input logic ld, input logic [7:0] d,
                        input logic cm, input logic [AW-1:0] a);
        @(negedge clk);
        guard_pin_n = pin; sel_n = sel; busy = bz; cycle_done = dn;
        set_wen = sw; clr_wen = cw; sr_load = ld; sr_data = d; sr_commit = cm; arr_addr = a;
        #1;
        check("R2 status", status_byte, exp_status());
        check("R5 arr_ok", {7'b0, arr_ok}, {7'b0, exp_arr_ok()});
        check("R6 sr_ok", {7'b0, sr_ok}, {7'b0, exp_sr_ok()});
        model_advance();
    endtask

    task automatic idle(input logic pin, input logic [AW-1:0] a);
        step(pin, 1, 0, 0, 0, 0, 0, 8'h00, 0, a);
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        idle(1, 0);
        check("R1 reset status", status_byte, 8'h00);

        step(1, 1, 0, 0, 1, 0, 0, 8'h00, 0, 0);
        idle(1, 0);
        check("R3 latch set", status_byte, 8'h02);

        // stage zone 01 with stray bits, then commit on deselect
        step(1, 0, 0, 0, 0, 0, 1, 8'h75, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 8'h00, 1, 0);
        idle(1, 14'h2FFF);
        check("R7 zone committed", status_byte, 8'h06);
        check("R4 below quarter", {7'b0, arr_ok}, 8'h01);
        idle(1, 14'h3000);
        check("R4 quarter start", {7'b0, arr_ok}, 8'h00);

        step(1, 1, 0, 1, 0, 0, 0, 8'h00, 0, 0);
        step(1, 1, 1, 0, 1, 0, 0, 8'h00, 0, 0);
        check("R2 busy image", status_byte, 8'hFF);
        idle(1, 0);
        check("R9 set ignored when busy", status_byte, 8'h04);

        // pin-enable on, zone none
        step(1, 1, 0, 0, 1, 0, 0, 8'h00, 0, 0);
        step(1, 0, 0, 0, 0, 0, 1, 8'h80, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 8'h00, 1, 0);
        idle(0, 14'h3FFF);
        check("R6 lock denies", {7'b0, sr_ok}, 8'h00);
        check("R5 pin ignored for array", {7'b0, arr_ok}, 8'h01);
        step(0, 0, 0, 0, 0, 0, 1, 8'h00, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0, 8'h00, 1, 0);
        idle(0, 0);
        check("R10 pin-enable kept", status_byte, 8'h82);

        // staged value discarded by a fall inside the frame
        idle(1, 0);
        step(1, 0, 0, 0, 0, 0, 1, 8'h8C, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 8'h00, 1, 0);
        idle(1, 0);
        check("R8 fall aborts", status_byte, 8'h82);

        // a fall after commit does not undo it
        step(1, 0, 0, 0, 0, 0, 1, 8'h8C, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 8'h00, 1, 0);
        idle(0, 0);
        idle(0, 0);
        check("R8 fall after commit", status_byte, 8'h8E);

        step(0, 1, 0, 0, 0, 1, 0, 8'h00, 0, 0);
        idle(0, 0);
        check("R3 clear with pin low", status_byte, 8'h8C);

        for (int i = 0; i < 4000; i++) begin
            logic [7:0] rv;
            rv = 8'($urandom);
            step(($urandom % 5) != 0, ($urandom % 3) == 0, ($urandom % 10) == 0,
                 ($urandom % 20) == 0, ($urandom % 4) == 0, ($urandom % 12) == 0,
                 ($urandom % 3) == 0, rv, ($urandom % 6) == 0, AW'($urandom));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule